// File: doc/BRIEF.md
# Core Wrapper Reset Sequencer

This block sits beside one core of a larger chip and owns that core's control, status and reset state. Three registers are reachable through a simple request port: a 16-bit I/O control register, a 16-bit status register and a one-bit reset control register. The control register can be rewritten under a mask, and it also has write-one-to-set and write-one-to-clear aliases. Every port access returns, one cycle later, the value the addressed register holds after that access.

A command interface starts one of two hardware sequences. The first is a disable: the caller's bits are written to control, the block waits 10 µs and then puts the core into reset. The second is a full reset: the block runs a disable, then releases reset while the clock is forced on, and then removes the forced clock. Each wait is counted in clock cycles from a clock-frequency parameter. The block does not run the disable steps if the core is already held in reset. A `core_up` output shows when the core is out of reset and clocked normally.

Top module: `corewrap_seq`

## Requirements
- R1: After reset the control register is 0, the reset bit is 1, `busy` is 0, `core_up` is 0 and `reg_rdata` is 0.
- R2: A write to offset 0x408 gives control = (old & ~mask) | (data & mask). The cycle after any accepted request, `reg_rdata` holds the value of the addressed register after the access.
- R3: Offset 0x400 ORs the data into control. Offset 0x404 clears every control bit that is 1 in the data. The mask has no effect on either alias, and both aliases return the new control value.
- R4: Offset 0x500 is the status register and takes the same masked update. Offset 0x800 is the reset register: bit 0 is the reset bit, it takes a masked update through mask bit 0, and it reads back in bit 0 with all other bits 0.
- R5: A write with a zero mask to 0x408 leaves control unchanged and returns its current value, the same as a read.
- R6: `core_up` is 1 exactly when control bit 0 (clock enable) is 1, control bit 1 (force clock) is 0 and the reset bit is 0.
- R7: A disable command (`cmd_full`=0) accepted while the core is out of reset writes `cmd_keep_bits` to control at once and raises `busy`. It sets the reset bit 10·CLK_MHZ cycles later, and `busy` falls 1·CLK_MHZ cycles after that.
- R8: A disable command accepted while the reset bit is 1 has no effect: control is unchanged and `busy` stays 0.
- R9: A full reset (`cmd_full`=1) from out of reset first runs the R7 disable with `cmd_keep_bits | cmd_rst_bits`. Where the disable would go idle, it instead writes keep|0x3 and clears the reset bit. After 1·CLK_MHZ cycles it writes (keep & ~0x2)|0x1. After another 1·CLK_MHZ cycles `busy` falls.
- R10: A full reset accepted while the reset bit is 1 skips the disable: in the same cycle it writes keep|0x3 and clears reset, and then it continues as in R9.
- R11: While `busy` is 1, register writes from the port and new commands are ignored. Port reads still return values.
- R12: An access to any other offset returns 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_wmask | input | DATA_W | Bit mask for masked writes |
| reg_rdata | output | DATA_W | Register value after the access, valid the next cycle |
| cmd_valid | input | 1 | Start a sequence (ignored while busy) |
| cmd_full | input | 1 | 0 = disable, 1 = full reset |
| cmd_keep_bits | input | CTRL_W | Control bits kept during and after the sequence |
| cmd_rst_bits | input | CTRL_W | Control bits applied only during the disable phase of a full reset |
| busy | output | 1 | A sequence is running |
| core_ctrl | output | CTRL_W | Control register, driven to the core |
| core_status | output | CTRL_W | Status register |
| core_in_reset | output | 1 | Reset bit, holds the core in reset |
| core_up | output | 1 | Core out of reset with a normal, unforced clock |

## Verification
The assertions assume that no port write hits the reset register or the control register in the same cycle that a command is accepted. They also assume that the reset bit changes only through the sequencer or through a port write to 0x800. The stimulus issues each command on a cycle with no register request. The one port write made during a sequence, to the status register, is made while `busy` is already high. A stray full-reset command is sent in that same cycle to show that it is dropped.

// File: rtl/cws_pkg.sv
package cws_pkg;
   // Register offsets (byte addresses inside the wrapper window)
   localparam logic [11:0] OFF_CTRL_SET = 12'h400;
   localparam logic [11:0] OFF_CTRL_CLR = 12'h404;
   localparam logic [11:0] OFF_CTRL     = 12'h408;
   localparam logic [11:0] OFF_STAT     = 12'h500;
   localparam logic [11:0] OFF_RESET    = 12'h800;

   // Control register bit positions that the sequencer and decode rely on
   localparam int unsigned CB_CLKEN = 0;
   localparam int unsigned CB_FORCE = 1;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_DIS_WAIT,
      SQ_DIS_HOLD,
      SQ_EN_FORCE,
      SQ_EN_SETTLE
   } seq_state_e;
endpackage

// File: rtl/cws_ustimer.sv
module cws_ustimer #(
   parameter int unsigned CLK_MHZ  = 200,
   parameter int unsigned LONG_US  = 10,
   parameter int unsigned SHORT_US = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic sel_long,
   output logic done
);
   localparam int unsigned LONG_CYC  = CLK_MHZ * LONG_US;
   localparam int unsigned SHORT_CYC = CLK_MHZ * SHORT_US;
   localparam int unsigned CW        = $clog2(LONG_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= sel_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/cws_regfile.sv
module cws_regfile
   import cws_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CTRL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wmask,
   input  logic              busy,
   input  logic              seq_ctrl_we,
   input  logic [CTRL_W-1:0] seq_ctrl_val,
   input  logic              seq_rst_set,
   input  logic              seq_rst_clr,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [CTRL_W-1:0] stat_q,
   output logic              rst_q,
   output logic [DATA_W-1:0] rdata
);
   logic [CTRL_W-1:0] wd, wm;
   logic [CTRL_W-1:0] c_new, s_new;
   logic              r_new;
   logic              wr_ok;
   logic              hit_set, hit_clr, hit_ctl, hit_stat, hit_rst;
   logic [DATA_W-1:0] rd_val;

   assign wd = wdata[CTRL_W-1:0];
   assign wm = wmask[CTRL_W-1:0];

   generate
      if (DATA_W > CTRL_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^{wdata[DATA_W-1:CTRL_W], wmask[DATA_W-1:CTRL_W]};
      end
   endgenerate

   assign hit_set  = (addr == ADDR_W'(OFF_CTRL_SET));
   assign hit_clr  = (addr == ADDR_W'(OFF_CTRL_CLR));
   assign hit_ctl  = (addr == ADDR_W'(OFF_CTRL));
   assign hit_stat = (addr == ADDR_W'(OFF_STAT));
   assign hit_rst  = (addr == ADDR_W'(OFF_RESET));
   assign wr_ok    = req && we && !busy;

   always_comb begin
      c_new = ctrl_q;
      s_new = stat_q;
      r_new = rst_q;
      if (wr_ok) begin
         if (hit_set)  c_new = ctrl_q | wd;
         if (hit_clr)  c_new = ctrl_q & ~wd;
         if (hit_ctl)  c_new = (ctrl_q & ~wm) | (wd & wm);
         if (hit_stat) s_new = (stat_q & ~wm) | (wd & wm);
         if (hit_rst)  r_new = (rst_q & ~wm[0]) | (wd[0] & wm[0]);
      end
      // sequencer actions take priority over a same-cycle port write
      if (seq_ctrl_we) c_new = seq_ctrl_val;
      if (seq_rst_set) r_new = 1'b1;
      if (seq_rst_clr) r_new = 1'b0;
   end

   always_comb begin
      rd_val = '0;
      if (hit_set || hit_clr || hit_ctl) rd_val = DATA_W'(c_new);
      else if (hit_stat)                 rd_val = DATA_W'(s_new);
      else if (hit_rst)                  rd_val = DATA_W'(r_new);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
         rst_q  <= 1'b1;
         rdata  <= '0;
      end else begin
         ctrl_q <= c_new;
         stat_q <= s_new;
         rst_q  <= r_new;
         if (req) rdata <= rd_val;
      end
   end
endmodule

// File: rtl/cws_seq.sv
module cws_seq
   import cws_pkg::*;
#(
   parameter int unsigned CTRL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_full,
   input  logic [CTRL_W-1:0] keep_bits,
   input  logic [CTRL_W-1:0] rst_bits,
   input  logic              in_reset,
   input  logic              tmr_done,
   output logic              busy,
   output logic              tmr_load,
   output logic              tmr_long,
   output logic              ctrl_we,
   output logic [CTRL_W-1:0] ctrl_val,
   output logic              rst_set,
   output logic              rst_clr
);
   localparam logic [CTRL_W-1:0] M_CLK   = CTRL_W'(1) << CB_CLKEN;
   localparam logic [CTRL_W-1:0] M_FORCE = CTRL_W'(1) << CB_FORCE;

   seq_state_e        st_q, st_d;
   logic              full_q, full_d;
   logic [CTRL_W-1:0] keep_q, keep_d;

   always_comb begin
      st_d     = st_q;
      full_d   = full_q;
      keep_d   = keep_q;
      tmr_load = 1'b0;
      tmr_long = 1'b0;
      ctrl_we  = 1'b0;
      ctrl_val = '0;
      rst_set  = 1'b0;
      rst_clr  = 1'b0;
      unique case (st_q)
         SQ_IDLE: begin
            if (cmd_valid) begin
               full_d = cmd_full;
               keep_d = keep_bits;
               if (!in_reset) begin
                  ctrl_we  = 1'b1;
                  ctrl_val = cmd_full ? (keep_bits | rst_bits) : keep_bits;
                  tmr_load = 1'b1;
                  tmr_long = 1'b1;
                  st_d     = SQ_DIS_WAIT;
               end else if (cmd_full) begin
                  ctrl_we  = 1'b1;
                  ctrl_val = keep_bits | M_FORCE | M_CLK;
                  rst_clr  = 1'b1;
                  tmr_load = 1'b1;
                  st_d     = SQ_EN_FORCE;
               end
            end
         end
         SQ_DIS_WAIT: begin
            if (tmr_done) begin
               rst_set  = 1'b1;
               tmr_load = 1'b1;
               st_d     = SQ_DIS_HOLD;
            end
         end
         SQ_DIS_HOLD: begin
            if (tmr_done) begin
               if (full_q) begin
                  ctrl_we  = 1'b1;
                  ctrl_val = keep_q | M_FORCE | M_CLK;
                  rst_clr  = 1'b1;
                  tmr_load = 1'b1;
                  st_d     = SQ_EN_FORCE;
               end else begin
                  st_d = SQ_IDLE;
               end
            end
         end
         SQ_EN_FORCE: begin
            if (tmr_done) begin
               ctrl_we  = 1'b1;
               ctrl_val = (keep_q & ~M_FORCE) | M_CLK;
               tmr_load = 1'b1;
               st_d     = SQ_EN_SETTLE;
            end
         end
         SQ_EN_SETTLE: begin
            if (tmr_done) st_d = SQ_IDLE;
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         full_q <= 1'b0;
         keep_q <= '0;
      end else begin
         st_q   <= st_d;
         full_q <= full_d;
         keep_q <= keep_d;
      end
   end

   assign busy = (st_q != SQ_IDLE);
endmodule

// File: rtl/corewrap_seq.sv
module corewrap_seq
   import cws_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CTRL_W   = 16,
   parameter int unsigned CLK_MHZ  = 200,
   parameter int unsigned LONG_US  = 10,
   parameter int unsigned SHORT_US = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_wmask,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cmd_valid,
   input  logic              cmd_full,
   input  logic [CTRL_W-1:0] cmd_keep_bits,
   input  logic [CTRL_W-1:0] cmd_rst_bits,
   output logic              busy,
   output logic [CTRL_W-1:0] core_ctrl,
   output logic [CTRL_W-1:0] core_status,
   output logic              core_in_reset,
   output logic              core_up
);
   generate
      if (CTRL_W < 16) begin : g_chk_ctrl
         $error("CTRL_W must hold the 16 defined control bits");
      end
      if (DATA_W < CTRL_W) begin : g_chk_data
         $error("DATA_W must be at least CTRL_W");
      end
      if (ADDR_W < 12) begin : g_chk_addr
         $error("ADDR_W must cover the 4 KiB wrapper window");
      end
      if (CLK_MHZ == 0 || SHORT_US == 0 || LONG_US < SHORT_US) begin : g_chk_tm
         $error("timer parameters out of range");
      end
   endgenerate

   logic              tmr_load, tmr_long, tmr_done;
   logic              s_ctrl_we, s_rst_set, s_rst_clr;
   logic [CTRL_W-1:0] s_ctrl_val;

   cws_ustimer #(
      .CLK_MHZ (CLK_MHZ),
      .LONG_US (LONG_US),
      .SHORT_US(SHORT_US)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .sel_long(tmr_long),
      .done    (tmr_done)
   );

   cws_seq #(
      .CTRL_W(CTRL_W)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_full (cmd_full),
      .keep_bits(cmd_keep_bits),
      .rst_bits (cmd_rst_bits),
      .in_reset (core_in_reset),
      .tmr_done (tmr_done),
      .busy     (busy),
      .tmr_load (tmr_load),
      .tmr_long (tmr_long),
      .ctrl_we  (s_ctrl_we),
      .ctrl_val (s_ctrl_val),
      .rst_set  (s_rst_set),
      .rst_clr  (s_rst_clr)
   );

   cws_regfile #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .CTRL_W(CTRL_W)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (reg_req),
      .we          (reg_we),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .wmask       (reg_wmask),
      .busy        (busy),
      .seq_ctrl_we (s_ctrl_we),
      .seq_ctrl_val(s_ctrl_val),
      .seq_rst_set (s_rst_set),
      .seq_rst_clr (s_rst_clr),
      .ctrl_q      (core_ctrl),
      .stat_q      (core_status),
      .rst_q       (core_in_reset),
      .rdata       (reg_rdata)
   );

   assign core_up = core_ctrl[CB_CLKEN] && !core_ctrl[CB_FORCE] && !core_in_reset;
endmodule

// File: rtl/cws_checker.sv
module cws_checker #(
   parameter int unsigned CTRL_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              cmd_valid,
   input logic              cmd_full,
   input logic [CTRL_W-1:0] core_ctrl,
   input logic [CTRL_W-1:0] core_status,
   input logic              core_in_reset,
   input logic              core_up
);
   // R6: a core held in reset is never reported up
   assert_up_blocked_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      core_in_reset |-> !core_up);

   // R9: a release made by the sequencer happens with the clock forced on
   assert_release_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(core_in_reset) && busy) |-> (core_ctrl[1] && core_ctrl[0]));

   // R9: every sequence ends with the core in reset or fully up
   assert_end_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (core_in_reset || core_up));

   // R8: a disable aimed at a core already in reset does not start
   assert_skip_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_full && !busy && core_in_reset) |=> !busy);

   // R7: a command for a running core starts a sequence
   assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !core_in_reset) |=> busy);

   // R11: the status register cannot change while a sequence runs
   assert_status_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(core_status));
endmodule

bind corewrap_seq cws_checker #(.CTRL_W(CTRL_W)) i_cws_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .cmd_valid    (cmd_valid),
   .cmd_full     (cmd_full),
   .core_ctrl    (core_ctrl),
   .core_status  (core_status),
   .core_in_reset(core_in_reset),
   .core_up      (core_up)
);

// File: tb/test_corewrap_seq.sv
module test_corewrap_seq;
   localparam int MHZ = 200;
   localparam int T10 = 10 * MHZ;
   localparam int T1  = MHZ;

   typedef struct packed {
      logic [11:0] addr;
      logic        we;
      logic [31:0] wd;
      logic [31:0] wm;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{12'h408, 1'b1, 32'h0000ABCD, 32'h0000FFFF, 32'h0000ABCD}, // R2 full masked write
      '{12'h408, 1'b1, 32'h00000000, 32'h000000F0, 32'h0000AB0D}, // R2 partial mask
      '{12'h404, 1'b1, 32'h0000000D, 32'h00000000, 32'h0000AB00}, // R3 clear alias
      '{12'h400, 1'b1, 32'h00000011, 32'h00000000, 32'h0000AB11}, // R3 set alias
      '{12'h408, 1'b1, 32'h00001234, 32'h00000000, 32'h0000AB11}, // R5 zero mask
      '{12'h408, 1'b0, 32'h00000000, 32'h00000000, 32'h0000AB11}, // R5 plain read
      '{12'h500, 1'b1, 32'h0000F00F, 32'h0000F0F0, 32'h0000F000}, // R4 status
      '{12'h500, 1'b1, 32'h00000ABC, 32'h00000FFF, 32'h0000FABC}, // R4 status
      '{12'h700, 1'b1, 32'h0000FFFF, 32'h0000FFFF, 32'h00000000}, // R12 unmapped
      '{12'h408, 1'b0, 32'h00000000, 32'h00000000, 32'h0000AB11}, // R12 no side effect
      '{12'h800, 1'b0, 32'h00000000, 32'h00000000, 32'h00000001}, // R4 reset bit
      '{12'h800, 1'b1, 32'h00000000, 32'h00000001, 32'h00000000}, // R4 release
      '{12'h800, 1'b1, 32'h00000001, 32'h00000001, 32'h00000001}  // R4 hold again
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_req = 1'b0, reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_wmask = '0;
   logic [31:0] reg_rdata;
   logic        cmd_valid = 1'b0, cmd_full = 1'b0;
   logic [15:0] cmd_keep_bits = '0, cmd_rst_bits = '0;
   logic        busy;
   logic [15:0] core_ctrl, core_status;
   logic        core_in_reset, core_up;

   int n_chk = 0;
   int n_fail = 0;
   logic wd_hit = 1'b0;

   always #2.5 clk = ~clk;

   corewrap_seq #(.CLK_MHZ(MHZ)) i_corewrap_seq (
      .clk(clk), .rst_n(rst_n),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
      .cmd_valid(cmd_valid), .cmd_full(cmd_full),
      .cmd_keep_bits(cmd_keep_bits), .cmd_rst_bits(cmd_rst_bits),
      .busy(busy), .core_ctrl(core_ctrl), .core_status(core_status),
      .core_in_reset(core_in_reset), .core_up(core_up)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_op(input logic [11:0] a, input logic w,
                         input logic [31:0] d, input logic [31:0] m);
      reg_req = 1'b1; reg_we = w; reg_addr = a; reg_wdata = d; reg_wmask = m;
      @(negedge clk);
      reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic cmd(input logic full, input logic [15:0] kb, input logic [15:0] rb);
      cmd_valid = 1'b1; cmd_full = full; cmd_keep_bits = kb; cmd_rst_bits = rb;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic run_tests();
      // R1 reset state
      tick(3);
      check("R1 ctrl", 32'(core_ctrl), 32'h0);
      check("R1 in_reset", 32'(core_in_reset), 32'h1);
      check("R1 busy", 32'(busy), 32'h0);
      check("R1 core_up", 32'(core_up), 32'h0);
      check("R1 rdata", reg_rdata, 32'h0);
      rst_n = 1'b1;
      tick(2);

      // R2 R3 R4 R5 R12 register table
      for (int i = 0; i < NV; i++) begin
         reg_op(VECS[i].addr, VECS[i].we, VECS[i].wd, VECS[i].wm);
         check($sformatf("vector %0d (R2/R3/R4/R5/R12)", i), reg_rdata, VECS[i].exp);
      end

      // R6 core-up decode
      reg_op(12'h408, 1'b1, 32'h0001, 32'hFFFF);
      check("R6 up while in reset", 32'(core_up), 32'h0);
      reg_op(12'h800, 1'b1, 32'h0, 32'h1);
      check("R6 up clocked", 32'(core_up), 32'h1);
      reg_op(12'h400, 1'b1, 32'h0002, 32'h0);
      check("R6 up with forced clock", 32'(core_up), 32'h0);
      reg_op(12'h404, 1'b1, 32'h0002, 32'h0);
      check("R6 up restored", 32'(core_up), 32'h1);

      // R7 disable from running core, with R11 ignored write and command
      cmd(1'b0, 16'h0040, 16'h0);
      check("R7 ctrl written", 32'(core_ctrl), 32'h0040);
      check("R7 busy", 32'(busy), 32'h1);
      reg_req = 1'b1; reg_we = 1'b1; reg_addr = 12'h500;
      reg_wdata = 32'h0; reg_wmask = 32'hFFFF;
      cmd_valid = 1'b1; cmd_full = 1'b1; cmd_keep_bits = 16'h7777;
      @(negedge clk);
      reg_req = 1'b0; reg_we = 1'b0; cmd_valid = 1'b0;
      tick(T10 - 2);
      check("R7 reset not yet", 32'(core_in_reset), 32'h0);
      tick(1);
      check("R7 reset asserted", 32'(core_in_reset), 32'h1);
      tick(T1 - 1);
      check("R7 still busy", 32'(busy), 32'h1);
      tick(1);
      check("R7 busy done", 32'(busy), 32'h0);
      tick(3);
      check("R11 stray command dropped", 32'(busy), 32'h0);
      check("R11 ctrl kept", 32'(core_ctrl), 32'h0040);
      reg_op(12'h500, 1'b0, 32'h0, 32'h0);
      check("R11 status write ignored", reg_rdata, 32'h0000FABC);

      // R8 disable while in reset
      cmd(1'b0, 16'h00FF, 16'h0);
      check("R8 busy stays low", 32'(busy), 32'h0);
      check("R8 ctrl unchanged", 32'(core_ctrl), 32'h0040);

      // R10 full reset while in reset
      cmd(1'b1, 16'h0100, 16'h0008);
      check("R10 forced clock", 32'(core_ctrl), 32'h0103);
      check("R10 reset released", 32'(core_in_reset), 32'h0);
      check("R10 not up", 32'(core_up), 32'h0);
      tick(T1 - 1);
      check("R10 still forced", 32'(core_ctrl), 32'h0103);
      tick(1);
      check("R10 clock normal", 32'(core_ctrl), 32'h0101);
      check("R10 up", 32'(core_up), 32'h1);
      tick(T1);
      check("R10 done", 32'(busy), 32'h0);

      // R9 full reset from running core
      cmd(1'b1, 16'h0200, 16'h0800);
      check("R9 disable bits", 32'(core_ctrl), 32'h0A00);
      check("R9 busy", 32'(busy), 32'h1);
      tick(T10 - 1);
      check("R9 reset not yet", 32'(core_in_reset), 32'h0);
      tick(1);
      check("R9 reset asserted", 32'(core_in_reset), 32'h1);
      tick(T1);
      check("R9 forced release ctrl", 32'(core_ctrl), 32'h0203);
      check("R9 released", 32'(core_in_reset), 32'h0);
      tick(T1);
      check("R9 clock normal", 32'(core_ctrl), 32'h0201);
      check("R9 up", 32'(core_up), 32'h1);
      check("R9 busy late", 32'(busy), 32'h1);
      tick(T1);
      check("R9 done", 32'(busy), 32'h0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (50000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule